// File: doc/BRIEF.md
# Drain-Source Short Fault Monitor

This block supervises the switches of an external four-switch power bridge. Each switch has a comparator that reports whether its drain-source voltage is above the short threshold. The block turns those reports into latched short-circuit faults. A report counts only while the switch is commanded on and after a blanking window that follows each turn-on. The block also takes status inputs for overtemperature, gate-regulator undervoltage and logic-supply undervoltage. From all of these it drives an output-disable signal and a two-bit fault flag code.

Each switch has its own three-state blanking machine. BK_OFF goes to BK_HOLD on a turn-on. BK_HOLD goes to BK_ARMED when the window ends. Either state goes back to BK_OFF on a turn-off or a clear. The window lasts `DEAD_CYC + EXTRA_CYC` clock cycles: the dead time plus a monitor-delay allowance. A separate control machine watches the active-low control reset. In RC_AWAKE a low level moves it to RC_PULSE. If the level is still low after `SLEEP_CYC` edges it moves to RC_SLEEP. From either of those states a high level returns it to RC_AWAKE. Any low level clears the latched faults. Holding the level low long enough also enters sleep.

Top module: `vds_fault_mon`

## Requirements
- R1: A comparator report for a switch whose gate command is low never sets that switch's latched short bit.
- R2: With BLANK = DEAD_CYC + EXTRA_CYC, a report is ignored on the first BLANK+1 rising clock edges of each continuous gate-on interval. The count restarts on every off-to-on change, and a turn-off aborts it.
- R3: A report on a later edge while the gate is on sets `short_fault[i]` (bit i = switch i). It also raises `flag_b` and `out_dis` from that edge onward, and all three persist after the report goes away.
- R4: While `det_off` is high, no short bit is set, and latched shorts contribute nothing to the flags or to `out_dis`.
- R5: `ot_warn` high drives `flag_a` high, leaves `out_dis` untouched, and stops contributing as soon as it drops.
- R6: `vreg_low` high drives both flags and `out_dis` high. These clear when it drops.
- R7: `v5_low` high drives both flags and `out_dis` high. On each edge while it is high, all latched short bits are cleared and none can be set.
- R8: When several conditions are active, each flag is the OR of what each condition alone would give it.
- R9: A `rst_cmd_n` low level shorter than SLEEP_CYC edges clears all latched short bits and leaves `asleep` at 0.
- R10: `rst_cmd_n` held low for SLEEP_CYC edges sets `asleep`. While asleep, `out_dis` is 1 and both flags are 0. The first edge with `rst_cmd_n` high clears `asleep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_cmd_n | input | 1 | Control reset: short low clears faults, long low enters sleep |
| gate_on | input | NSW | Gate command per switch, 1 = on |
| vds_hi | input | NSW | Comparator result per switch, 1 = drain-source above threshold |
| det_off | input | 1 | Short detection disable |
| ot_warn | input | 1 | Overtemperature status |
| vreg_low | input | 1 | Gate-regulator undervoltage status |
| v5_low | input | 1 | Logic-supply undervoltage status |
| short_fault | output | NSW | Latched short fault per switch |
| out_dis | output | 1 | Output disable |
| flag_a | output | 1 | First fault flag |
| flag_b | output | 1 | Second fault flag |
| asleep | output | 1 | Sleep state |

## Verification
The bench holds the comparator high across the exact edge where blanking ends. A window that is one cycle too short latches a fault inside the blanking time. A window that is one cycle too long misses the expected latch. Gate pulses shorter than the window, followed by a fresh turn-on, expose a counter that resumes instead of restarting. A logic-supply undervoltage pulse with a short already latched shows whether the wipe really happens. A one-cycle control-reset pulse and a long low level check that sleep is entered at the exact edge and not on a short pulse.

// File: rtl/vds_mon_pkg.sv
package vds_mon_pkg;
    typedef enum logic [1:0] {
        BK_OFF   = 2'd0,
        BK_HOLD  = 2'd1,
        BK_ARMED = 2'd2
    } blank_st_t;

    typedef enum logic [1:0] {
        RC_AWAKE = 2'd0,
        RC_PULSE = 2'd1,
        RC_SLEEP = 2'd2
    } rc_st_t;
endpackage

// File: rtl/vds_blank_gate.sv
module vds_blank_gate
    import vds_mon_pkg::*;
#(
    parameter int BLANK = 9
) (
    input  logic clk,
    input  logic arst_n,
    input  logic clr,
    input  logic gate_on,
    output logic armed
);
    localparam int CW = $clog2(BLANK + 1);
    localparam logic [CW-1:0] LAST = CW'(BLANK - 1);

    blank_st_t st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st  <= BK_OFF;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            BK_OFF: begin
                cnt_nx = '0;
                if (gate_on) st_nx = BK_HOLD;
            end
            BK_HOLD: begin
                if (!gate_on) begin
                    st_nx  = BK_OFF;
                    cnt_nx = '0;
                end else if (cnt == LAST) begin
                    st_nx = BK_ARMED;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            BK_ARMED: begin
                if (!gate_on) st_nx = BK_OFF;
            end
            default: st_nx = BK_OFF;
        endcase
        if (clr) begin
            st_nx  = BK_OFF;
            cnt_nx = '0;
        end
    end

    always_comb armed = (st == BK_ARMED) && gate_on;

    // R2
    blank_after_rise_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (gate_on && !$past(gate_on)) |-> !armed);
endmodule

// File: rtl/vds_rst_ctl.sv
module vds_rst_ctl
    import vds_mon_pkg::*;
#(
    parameter int SLEEP_CYC = 20
) (
    input  logic clk,
    input  logic arst_n,
    input  logic rst_cmd_n,
    output logic asleep
);
    localparam int CW = $clog2(SLEEP_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SLEEP_CYC - 1);

    rc_st_t st, st_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st  <= RC_AWAKE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            RC_AWAKE: begin
                cnt_nx = CW'(1);
                if (!rst_cmd_n) st_nx = (LAST == '0) ? RC_SLEEP : RC_PULSE;
            end
            RC_PULSE: begin
                if (rst_cmd_n) st_nx = RC_AWAKE;
                else if (cnt == LAST) st_nx = RC_SLEEP;
                else cnt_nx = cnt + 1'b1;
            end
            RC_SLEEP: begin
                if (rst_cmd_n) st_nx = RC_AWAKE;
            end
            default: st_nx = RC_AWAKE;
        endcase
    end

    always_comb asleep = (st == RC_SLEEP);

    // R10
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(asleep) |-> !$past(rst_cmd_n));
endmodule

// File: rtl/vds_flag_enc.sv
module vds_flag_enc #(
    parameter int NSW = 4
) (
    input  logic [NSW-1:0] short_lat,
    input  logic           det_off,
    input  logic           ot_warn,
    input  logic           vreg_low,
    input  logic           v5_low,
    input  logic           asleep,
    output logic           out_dis,
    output logic           flag_a,
    output logic           flag_b
);
    logic short_any;
    logic supply_low;

    always_comb begin
        short_any  = (|short_lat) && !det_off;
        supply_low = vreg_low || v5_low;
        out_dis    = asleep || short_any || supply_low;
        flag_a     = !asleep && (ot_warn || supply_low);
        flag_b     = !asleep && (short_any || supply_low);
    end
endmodule

// File: rtl/vds_fault_mon.sv
module vds_fault_mon #(
    parameter int NSW       = 4,
    parameter int DEAD_CYC  = 6,
    parameter int EXTRA_CYC = 3,
    parameter int SLEEP_CYC = 20
) (
    input  logic           clk,
    input  logic           arst_n,
    input  logic           rst_cmd_n,
    input  logic [NSW-1:0] gate_on,
    input  logic [NSW-1:0] vds_hi,
    input  logic           det_off,
    input  logic           ot_warn,
    input  logic           vreg_low,
    input  logic           v5_low,
    output logic [NSW-1:0] short_fault,
    output logic           out_dis,
    output logic           flag_a,
    output logic           flag_b,
    output logic           asleep
);
    localparam int BLANK = DEAD_CYC + EXTRA_CYC;

    logic [NSW-1:0] armed;
    logic [NSW-1:0] short_lat;
    logic           clr_all;

    always_comb clr_all = !rst_cmd_n || v5_low;

    for (genvar i = 0; i < NSW; i++) begin : g_sw
        vds_blank_gate #(.BLANK(BLANK)) u_blank (
            .clk     (clk),
            .arst_n  (arst_n),
            .clr     (!rst_cmd_n),
            .gate_on (gate_on[i]),
            .armed   (armed[i])
        );
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) short_lat <= '0;
        else if (clr_all) short_lat <= '0;
        else short_lat <= short_lat | (armed & vds_hi & {NSW{!det_off}});
    end

    vds_rst_ctl #(.SLEEP_CYC(SLEEP_CYC)) u_rctl (
        .clk       (clk),
        .arst_n    (arst_n),
        .rst_cmd_n (rst_cmd_n),
        .asleep    (asleep)
    );

    vds_flag_enc #(.NSW(NSW)) u_enc (
        .short_lat (short_lat),
        .det_off   (det_off),
        .ot_warn   (ot_warn),
        .vreg_low  (vreg_low),
        .v5_low    (v5_low),
        .asleep    (asleep),
        .out_dis   (out_dis),
        .flag_a    (flag_a),
        .flag_b    (flag_b)
    );

    always_comb short_fault = short_lat;

    // R1
    off_no_latch_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (short_lat & ~$past(short_lat) & ~$past(gate_on)) == '0);

    // R4
    det_off_no_latch_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $past(det_off) |-> ((short_lat & ~$past(short_lat)) == '0));

    // R7
    v5_wipe_chk: assert property (@(posedge clk) disable iff (!arst_n)
        $past(v5_low) |-> (short_lat == '0));

    // R7
    v5_flags_chk: assert property (@(posedge clk) disable iff (!arst_n)
        (v5_low && !asleep) |-> (out_dis && flag_a && flag_b));

    // R9
    pulse_clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !$past(rst_cmd_n) |-> (short_fault == '0));

    // R6
    vreg_dis_chk: assert property (@(posedge clk) disable iff (!arst_n)
        vreg_low |-> out_dis);
endmodule

// File: tb/sim_vds_fault_mon.sv
module sim_vds_fault_mon;
    localparam int NSW = 4, DEAD = 6, EXTRA = 3, SLP = 20;
    localparam int BLANK = DEAD + EXTRA;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic rst_cmd_n = 1'b1;
    logic [NSW-1:0] gate_on = '0, vds_hi = '0;
    logic det_off = 1'b0, ot_warn = 1'b0, vreg_low = 1'b0, v5_low = 1'b0;
    logic [NSW-1:0] short_fault;
    logic out_dis, flag_a, flag_b, asleep;

    vds_fault_mon #(.NSW(NSW), .DEAD_CYC(DEAD), .EXTRA_CYC(EXTRA), .SLEEP_CYC(SLP)) u0 (
        .clk(clk), .arst_n(arst_n), .rst_cmd_n(rst_cmd_n), .gate_on(gate_on),
        .vds_hi(vds_hi), .det_off(det_off), .ot_warn(ot_warn), .vreg_low(vreg_low),
        .v5_low(v5_low), .short_fault(short_fault), .out_dis(out_dis),
        .flag_a(flag_a), .flag_b(flag_b), .asleep(asleep));

    always #10 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R3";
    int run [NSW];
    int lowrun = 0;
    logic [NSW-1:0] m_short = '0;
    logic m_sleep = 1'b0;

    task automatic check();
        logic sa;
        logic [NSW+3:0] exp_v, act_v;
        sa = !det_off && (|m_short);
        exp_v = {m_short,
                 m_sleep || sa || vreg_low || v5_low,
                 !m_sleep && (ot_warn || vreg_low || v5_low),
                 !m_sleep && (sa || vreg_low || v5_low),
                 m_sleep};
        act_v = {short_fault, out_dis, flag_a, flag_b, asleep};
        n_cmp++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%b expected=%b (short,dis,fa,fb,sleep)",
                     cur_req, $time, act_v, exp_v);
        end
    endtask

    task automatic update();
        logic [NSW-1:0] arm;
        for (int i = 0; i < NSW; i++)
            arm[i] = gate_on[i] && (run[i] >= BLANK + 1);
        if (!rst_cmd_n || v5_low) m_short = '0;
        else m_short = m_short | (arm & vds_hi & {NSW{!det_off}});
        for (int i = 0; i < NSW; i++)
            run[i] = (!rst_cmd_n || !gate_on[i]) ? 0 : run[i] + 1;
        lowrun = rst_cmd_n ? 0 : lowrun + 1;
        m_sleep = !rst_cmd_n && (lowrun >= SLP);
    endtask

    task automatic step(input logic [NSW-1:0] g, input logic [NSW-1:0] v,
                        input logic dof, input logic ot, input logic vr,
                        input logic v5, input logic rc, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check();
            gate_on = g; vds_hi = v; det_off = dof; ot_warn = ot;
            vreg_low = vr; v5_low = v5; rst_cmd_n = rc;
            @(posedge clk);
            update();
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NSW; i++) run[i] = 0;
        repeat (3) @(negedge clk);
        arst_n = 1'b1;
        cur_req = "R3"; step('0, '0, 0, 0, 0, 0, 1, 2);          // reset state
        cur_req = "R1"; step(4'b0000, 4'b1111, 0, 0, 0, 0, 1, 12);
        cur_req = "R1"; step(4'b0101, 4'b1010, 0, 0, 0, 0, 1, 15);
        step('0, '0, 0, 0, 0, 0, 1, 2);
        // R2: comparator high through the whole blanking window, then off
        cur_req = "R2"; step(4'b0001, 4'b0001, 0, 0, 0, 0, 1, BLANK + 1);
        step(4'b0000, 4'b0001, 0, 0, 0, 0, 1, 2);
        // R2: restart after short on pulses
        step(4'b0001, 4'b0000, 0, 0, 0, 0, 1, BLANK - 2);
        step(4'b0000, 4'b0000, 0, 0, 0, 0, 1, 1);
        step(4'b0001, 4'b0001, 0, 0, 0, 0, 1, BLANK + 1);
        // R2 / R3: exactly the first armed edge
        cur_req = "R3"; step(4'b0001, 4'b0001, 0, 0, 0, 0, 1, 1);
        step(4'b0001, 4'b0000, 0, 0, 0, 0, 1, 5);
        step(4'b0000, 4'b0000, 0, 0, 0, 0, 1, 3);
        cur_req = "R9"; step('0, '0, 0, 0, 0, 0, 0, 1);
        step('0, '0, 0, 0, 0, 0, 1, 3);
        // R4
        cur_req = "R4"; step(4'b1000, 4'b1000, 1, 0, 0, 0, 1, BLANK + 6);
        step(4'b1000, 4'b0000, 1, 0, 0, 0, 1, 2);
        step(4'b1000, 4'b1000, 0, 0, 0, 0, 1, 2);
        step(4'b1000, 4'b0000, 1, 0, 0, 0, 1, 3);
        step(4'b0000, 4'b0000, 0, 0, 0, 0, 0, 1);
        // R5
        cur_req = "R5"; step('0, '0, 0, 1, 0, 0, 1, 4);
        step('0, '0, 0, 0, 0, 0, 1, 2);
        // R6
        cur_req = "R6"; step('0, '0, 0, 0, 1, 0, 1, 4);
        step('0, '0, 0, 0, 0, 0, 1, 2);
        // R7: latch on switch 2, then logic-supply dip wipes it
        cur_req = "R7"; step(4'b0100, 4'b0000, 0, 0, 0, 0, 1, BLANK + 2);
        step(4'b0100, 4'b0100, 0, 0, 0, 0, 1, 2);
        step(4'b0100, 4'b0100, 0, 0, 0, 1, 1, 3);
        step(4'b0100, 4'b0000, 0, 0, 0, 0, 1, 3);
        // R8: overtemp together with a latched short
        cur_req = "R8"; step(4'b0100, 4'b0100, 0, 1, 0, 0, 1, 3);
        step(4'b0100, 4'b0000, 0, 1, 1, 0, 1, 3);
        step(4'b0000, 4'b0000, 0, 0, 0, 0, 1, 2);
        // R10: long low enters sleep, high leaves it
        cur_req = "R10"; step('0, '0, 0, 1, 0, 0, 0, SLP + 4);
        step('0, '0, 0, 1, 0, 0, 1, 3);
        step('0, '0, 0, 0, 0, 0, 0, SLP - 1);
        step('0, '0, 0, 0, 0, 0, 1, 3);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule